// File: doc/BRIEF.md
# Dual-Clock Synchronous RAM with Per-Port Read Latency

This block is a true two-port memory. Each port has its own clock and its own registered address, read/write strobe and pair of chip selects. Each port can reach every word, and both ports may access the same word in the same cycle. If both ports write one address at the same moment, the word that is left is undefined. Write data is taken on the rising edge. Read data leaves through a per-port output stage, and a static mode input picks its latency. With the mode input low, the port runs in flow-through mode: the word at the address taken on an edge is presented within that same clock cycle. With the mode input high, the port runs pipelined: one output register is added, so data and its drive state appear one edge later.

The port is selected only when its active-low select is low and its active-high select is high. The output enable is not clocked; it gates the drive of read data at any moment. Electrical tristating is modelled as a drive flag (`*_rdata_oe`). While that flag is low, the data bus is held at zero. The address comes from an external address generator. The depth and width are parameters: the address width is typically 15 to 17 bits, and the data width is 8 or 9 bits.

Top module: `dpram_dual_clock`

## Requirements
- R1: A port is selected only when its `ce0_n` is 0 and its `ce1` is 1 at a rising edge. With either of the other three combinations, a write strobe at that edge leaves the memory unchanged, and the port's output is undriven in the following cycle (`rdata_oe`=0, `rdata`=0).
- R2: At a selected edge, `wr_n`=0 stores `wdata` at `addr`. `wr_n`=1 is a read.
- R3: With `pipe`=0 (flow-through), a selected read at an edge drives `rdata_oe`=1 and `rdata` = the word at that edge's address, during the cycle that follows that edge.
- R4: With `pipe`=1 (pipelined), the word for a read taken at edge k appears, with `rdata_oe`=1, only after edge k+1.
- R5: `oe_n`=1 forces `rdata_oe`=0 and `rdata`=0 at once, with no clock edge. Returning `oe_n` to 0 restores the drive at once.
- R6: In pipelined mode, the drive state in a cycle comes from the controls of the cycle before it. After a deselect, data stays driven for one more cycle. After a reselect, one selected cycle passes before the output drives again.
- R7: A write cycle never drives read data. In flow-through mode the output is undriven in the cycle after the write edge. In pipelined mode it is undriven one cycle later still.
- R8: A word written by one port is returned by a read that the other port takes at any of its own edges later than the write edge.
- R9: After reset, both ports' outputs are undriven and zero, and the pipelined output register holds zero with its valid flag cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Port A clock |
| clk_b | input | 1 | Port B clock |
| rst_n | input | 1 | Asynchronous active-low reset of both ports' control state |
| a_addr | input | ADDR_W | Port A word address |
| a_wr_n | input | 1 | Port A strobe: 0 write, 1 read |
| a_ce0_n | input | 1 | Port A select, active low |
| a_ce1 | input | 1 | Port A select, active high |
| a_oe_n | input | 1 | Port A unclocked output enable, active low |
| a_pipe | input | 1 | Port A latency mode: 0 flow-through, 1 pipelined |
| a_wdata | input | DATA_W | Port A write data |
| a_rdata | output | DATA_W | Port A read data, zero when undriven |
| a_rdata_oe | output | 1 | Port A data drive flag |
| b_addr | input | ADDR_W | Port B word address |
| b_wr_n | input | 1 | Port B strobe: 0 write, 1 read |
| b_ce0_n | input | 1 | Port B select, active low |
| b_ce1 | input | 1 | Port B select, active high |
| b_oe_n | input | 1 | Port B unclocked output enable, active low |
| b_pipe | input | 1 | Port B latency mode: 0 flow-through, 1 pipelined |
| b_wdata | input | DATA_W | Port B write data |
| b_rdata | output | DATA_W | Port B read data, zero when undriven |
| b_rdata_oe | output | 1 | Port B data drive flag |

## Verification
The bench runs on a 64-word, 9-bit configuration. Port A fills every word with an arithmetic pattern, and port B sweeps every word back, first in flow-through mode and then pipelined. This separates same-cycle data from data one edge late. Port B then overwrites the odd words, and port A reads the whole array pipelined. Every word whose writer was the other port therefore checks the crossing between the two banks, and words changed and unchanged tell a lost write apart from a wrong decode. The last patterns each toggle one control alone: the three deselecting select combinations (a write must not land), an output-enable pulse inside a cycle, a deselect/reselect pair in pipelined mode, and write-then-read in both modes.

// File: rtl/dpr_pkg.sv
`timescale 1ns/1ps
package dpr_pkg;
    typedef enum logic {
        MODE_FLOW = 1'b0,
        MODE_PIPE = 1'b1
    } rd_mode_e;

    localparam int NUM_PORTS = 2;
    // bank read taps: one per port access address, one for the other port's write address
    localparam int BANK_TAPS = NUM_PORTS + 1;
    localparam int TAP_XWR   = NUM_PORTS;
endpackage

// File: rtl/dpr_bank.sv
`timescale 1ns/1ps
module dpr_bank #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 9,
    parameter int TAPS   = 3
) (
    input  logic                         clk,
    input  logic                         we,
    input  logic [ADDR_W-1:0]            waddr,
    input  logic [DATA_W-1:0]            wdata,
    input  logic [TAPS-1:0][ADDR_W-1:0]  raddr,
    output logic [TAPS-1:0][DATA_W-1:0]  rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] store_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            store_q[waddr] <= wdata;
        end
    end

    for (genvar t = 0; t < TAPS; t++) begin : g_tap
        assign rdata[t] = store_q[raddr[t]];
    end
endmodule

// File: rtl/dpr_port.sv
`timescale 1ns/1ps
module dpr_port
    import dpr_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_n,
    input  logic              ce0_n,
    input  logic              ce1,
    input  logic              oe_n,
    input  logic              pipe_mode,
    input  logic [DATA_W-1:0] arr_rdata,
    output logic              wr_en,
    output logic [ADDR_W-1:0] acc_addr,
    output logic [DATA_W-1:0] rdata,
    output logic              rdata_oe
);
    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              sel;
        logic              rd;
        logic [DATA_W-1:0] pdata;
        logic              pvld;
    } port_st_t;

    port_st_t st_d, st_q;
    rd_mode_e mode;
    logic     pin_sel;
    logic     drive;

    assign mode    = rd_mode_e'(pipe_mode);
    assign pin_sel = !ce0_n && ce1;
    assign wr_en   = pin_sel && !wr_n;

    always_comb begin
        st_d       = st_q;
        st_d.addr  = addr;
        st_d.sel   = pin_sel;
        st_d.rd    = wr_n;
        st_d.pdata = arr_rdata;
        st_d.pvld  = st_q.sel && st_q.rd;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign acc_addr = st_q.addr;

    always_comb begin
        if (mode == MODE_PIPE) begin
            drive = st_q.pvld && !oe_n;
            rdata = drive ? st_q.pdata : '0;
        end else begin
            drive = st_q.sel && st_q.rd && !oe_n;
            rdata = drive ? arr_rdata : '0;
        end
        rdata_oe = drive;
    end

    // R5
    oe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rdata_oe |-> !oe_n);

    // R1
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rdata_oe |-> (rdata == '0));

    // R3
    ft_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pipe_mode && rdata_oe) |-> $past(!ce0_n && ce1 && wr_n));

    // R6
    pipe_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pipe_mode && rdata_oe) |-> $past(!ce0_n && ce1 && wr_n, 2));

    // R4
    pvld_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.pvld |-> $past(st_q.sel && st_q.rd));
endmodule

// File: rtl/dpram_dual_clock.sv
`timescale 1ns/1ps
module dpram_dual_clock
    import dpr_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 9
) (
    input  logic              clk_a,
    input  logic              clk_b,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic              a_wr_n,
    input  logic              a_ce0_n,
    input  logic              a_ce1,
    input  logic              a_oe_n,
    input  logic              a_pipe,
    input  logic [DATA_W-1:0] a_wdata,
    output logic [DATA_W-1:0] a_rdata,
    output logic              a_rdata_oe,
    input  logic [ADDR_W-1:0] b_addr,
    input  logic              b_wr_n,
    input  logic              b_ce0_n,
    input  logic              b_ce1,
    input  logic              b_oe_n,
    input  logic              b_pipe,
    input  logic [DATA_W-1:0] b_wdata,
    output logic [DATA_W-1:0] b_rdata,
    output logic              b_rdata_oe
);
    logic [NUM_PORTS-1:0]                          clk_v, wr_n_v, ce0_n_v, ce1_v, oe_n_v, pipe_v;
    logic [NUM_PORTS-1:0]                          wr_en_v, oe_v;
    logic [NUM_PORTS-1:0][ADDR_W-1:0]              addr_v, acc_v;
    logic [NUM_PORTS-1:0][DATA_W-1:0]              wdata_v, rdata_v, arr_v, enc_v;
    logic [NUM_PORTS-1:0][BANK_TAPS-1:0][DATA_W-1:0] bank_rd;

    assign clk_v   = {clk_b, clk_a};
    assign addr_v  = {b_addr, a_addr};
    assign wr_n_v  = {b_wr_n, a_wr_n};
    assign ce0_n_v = {b_ce0_n, a_ce0_n};
    assign ce1_v   = {b_ce1, a_ce1};
    assign oe_n_v  = {b_oe_n, a_oe_n};
    assign pipe_v  = {b_pipe, a_pipe};
    assign wdata_v = {b_wdata, a_wdata};

    assign a_rdata    = rdata_v[0];
    assign a_rdata_oe = oe_v[0];
    assign b_rdata    = rdata_v[1];
    assign b_rdata_oe = oe_v[1];

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        localparam int OTHER = NUM_PORTS - 1 - p;

        // each bank holds word ^ other bank, so a read is the XOR of both banks
        assign enc_v[p] = wdata_v[p] ^ bank_rd[OTHER][TAP_XWR];
        assign arr_v[p] = bank_rd[0][p] ^ bank_rd[1][p];

        dpr_bank #(
            .ADDR_W (ADDR_W),
            .DATA_W (DATA_W),
            .TAPS   (BANK_TAPS)
        ) u_bank (
            .clk   (clk_v[p]),
            .we    (wr_en_v[p]),
            .waddr (addr_v[p]),
            .wdata (enc_v[p]),
            .raddr ({addr_v[OTHER], acc_v[1], acc_v[0]}),
            .rdata (bank_rd[p])
        );

        dpr_port #(
            .ADDR_W (ADDR_W),
            .DATA_W (DATA_W)
        ) u_port (
            .clk       (clk_v[p]),
            .rst_n     (rst_n),
            .addr      (addr_v[p]),
            .wr_n      (wr_n_v[p]),
            .ce0_n     (ce0_n_v[p]),
            .ce1       (ce1_v[p]),
            .oe_n      (oe_n_v[p]),
            .pipe_mode (pipe_v[p]),
            .arr_rdata (arr_v[p]),
            .wr_en     (wr_en_v[p]),
            .acc_addr  (acc_v[p]),
            .rdata     (rdata_v[p]),
            .rdata_oe  (oe_v[p])
        );
    end
endmodule

// File: tb/dpram_dual_clock_tb.sv
`timescale 1ns/1ps
module dpram_dual_clock_tb;
    localparam int AW = 6;
    localparam int DW = 9;
    localparam int N  = 1 << AW;

    logic clk_a = 1'b0, clk_b = 1'b0, rst_n = 1'b0;
    logic [AW-1:0] a_addr = '0, b_addr = '0;
    logic a_wr_n = 1'b1, a_ce0_n = 1'b1, a_ce1 = 1'b0, a_oe_n = 1'b0, a_pipe = 1'b0;
    logic b_wr_n = 1'b1, b_ce0_n = 1'b1, b_ce1 = 1'b0, b_oe_n = 1'b0, b_pipe = 1'b1;
    logic [DW-1:0] a_wdata = '0, b_wdata = '0;
    logic [DW-1:0] a_rdata, b_rdata;
    logic a_rdata_oe, b_rdata_oe;

    logic [DW-1:0] expm [N];
    int checks = 0;
    int errors = 0;

    always #2.5 clk_a = ~clk_a;
    always #3.5 clk_b = ~clk_b;

    dpram_dual_clock #(.ADDR_W(AW), .DATA_W(DW)) u_dut (
        .clk_a(clk_a), .clk_b(clk_b), .rst_n(rst_n),
        .a_addr(a_addr), .a_wr_n(a_wr_n), .a_ce0_n(a_ce0_n), .a_ce1(a_ce1),
        .a_oe_n(a_oe_n), .a_pipe(a_pipe), .a_wdata(a_wdata),
        .a_rdata(a_rdata), .a_rdata_oe(a_rdata_oe),
        .b_addr(b_addr), .b_wr_n(b_wr_n), .b_ce0_n(b_ce0_n), .b_ce1(b_ce1),
        .b_oe_n(b_oe_n), .b_pipe(b_pipe), .b_wdata(b_wdata),
        .b_rdata(b_rdata), .b_rdata_oe(b_rdata_oe)
    );

    function automatic logic [DW-1:0] pat1(int a);
        return DW'((a * 37 + 11) % 512);
    endfunction

    function automatic logic [DW-1:0] pat2(int a);
        return DW'((a * 101 + 300) % 512);
    endfunction

    task automatic chk(string tag, int act, int expv);
        checks++;
        if (act != expv) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    // set pins at a falling edge, return at the next falling edge
    task automatic step_a(logic c0n, logic c1, logic wrn, int ad, logic [DW-1:0] wd);
        a_ce0_n = c0n; a_ce1 = c1; a_wr_n = wrn; a_addr = AW'(ad); a_wdata = wd;
        @(negedge clk_a);
    endtask

    task automatic step_b(logic c0n, logic c1, logic wrn, int ad, logic [DW-1:0] wd);
        b_ce0_n = c0n; b_ce1 = c1; b_wr_n = wrn; b_addr = AW'(ad); b_wdata = wd;
        @(negedge clk_b);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #1_000_000;
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        #21 rst_n = 1'b1;
        #1;
        // R9 reset state, port B already pipelined
        chk("R9 a_oe", a_rdata_oe, 0);
        chk("R9 a_data", a_rdata, 0);
        chk("R9 b_oe", b_rdata_oe, 0);
        chk("R9 b_data", b_rdata, 0);

        // R2 R7: port A fills memory in flow-through mode
        @(negedge clk_a);
        for (int a = 0; a < N; a++) begin
            step_a(0, 1, 0, a, pat1(a));
            expm[a] = pat1(a);
            chk("R7 ft write undriven", a_rdata_oe, 0);
        end
        step_a(1, 0, 1, 0, '0);

        // R3 R8: port B flow-through sweep
        @(negedge clk_b);
        b_pipe = 1'b0;
        for (int a = 0; a < N; a++) begin
            step_b(0, 1, 1, a, '0);
            chk("R3 oe", b_rdata_oe, 1);
            chk("R3 R8 data", b_rdata, expm[a]);
        end

        // R4: port B pipelined sweep, one edge behind
        b_pipe = 1'b1;
        step_b(0, 1, 1, 0, '0);
        for (int a = 1; a < N; a++) begin
            step_b(0, 1, 1, a, '0);
            chk("R4 oe", b_rdata_oe, 1);
            chk("R4 data", b_rdata, expm[a-1]);
        end
        step_b(1, 0, 1, 0, '0);
        chk("R6 last word after deselect", b_rdata, expm[N-1]);
        step_b(1, 0, 1, 0, '0);
        chk("R6 undriven after deselect", b_rdata_oe, 0);

        // R2: port B rewrites odd words in pipelined mode
        for (int a = 1; a < N; a += 2) begin
            step_b(0, 1, 0, a, pat2(a));
            expm[a] = pat2(a);
            if (a >= 3) chk("R7 pipe write undriven", b_rdata_oe, 0);
        end
        step_b(1, 0, 1, 0, '0);

        // R8 R4: port A pipelined sweep of data written by both ports
        @(negedge clk_a);
        a_pipe = 1'b1;
        step_a(0, 1, 1, 0, '0);
        for (int a = 1; a < N; a++) begin
            step_a(0, 1, 1, a, '0);
            chk("R8 R4 data", a_rdata, expm[a-1]);
        end
        step_a(1, 0, 1, 0, '0);
        chk("R8 R4 last", a_rdata, expm[N-1]);
        step_a(1, 0, 1, 0, '0);
        a_pipe = 1'b0;

        // R1: the three deselecting combinations
        for (int i = 0; i < 3; i++) begin
            logic c0n, c1;
            c0n = (i != 0);
            c1  = (i == 2);
            step_a(c0n, c1, 0, 3 + i, ~expm[3 + i]);
            chk("R1 write undriven", a_rdata_oe, 0);
            step_a(c0n, c1, 1, 3 + i, '0);
            chk("R1 read undriven", a_rdata_oe, 0);
            chk("R1 read zero", a_rdata, 0);
            step_a(0, 1, 1, 3 + i, '0);
            chk("R1 write ignored", a_rdata, expm[3 + i]);
        end

        // R5: unclocked output enable inside one cycle
        step_a(0, 1, 1, 7, '0);
        chk("R5 driven", a_rdata_oe, 1);
        #0.5 a_oe_n = 1'b1;
        #0.5;
        chk("R5 oe off", a_rdata_oe, 0);
        chk("R5 data zero", a_rdata, 0);
        a_oe_n = 1'b0;
        #0.5;
        chk("R5 oe back", a_rdata_oe, 1);
        chk("R5 data back", a_rdata, expm[7]);
        @(negedge clk_a);
        step_a(1, 0, 1, 0, '0);

        // R6: pipelined deselect and reselect on port B
        @(negedge clk_b);
        step_b(0, 1, 1, 9, '0);
        step_b(1, 0, 1, 9, '0);
        chk("R6 still driven", b_rdata_oe, 1);
        chk("R6 still data", b_rdata, expm[9]);
        step_b(1, 0, 1, 9, '0);
        chk("R6 off", b_rdata_oe, 0);
        step_b(0, 1, 1, 12, '0);
        chk("R6 reselect waits", b_rdata_oe, 0);
        step_b(0, 1, 1, 12, '0);
        chk("R6 reselect on", b_rdata_oe, 1);
        chk("R6 reselect data", b_rdata, expm[12]);
        step_b(1, 0, 1, 0, '0);

        // R8: crossing in both directions
        @(negedge clk_a);
        step_a(0, 1, 0, 20, 9'h155);
        expm[20] = 9'h155;
        step_a(1, 0, 1, 0, '0);
        @(negedge clk_b);
        b_pipe = 1'b0;
        step_b(0, 1, 1, 20, '0);
        chk("R8 a to b", b_rdata, expm[20]);
        step_b(0, 1, 0, 21, 9'h0aa);
        expm[21] = 9'h0aa;
        step_b(1, 0, 1, 0, '0);
        @(negedge clk_a);
        step_a(0, 1, 1, 21, '0);
        chk("R8 b to a", a_rdata, expm[21]);
        step_a(1, 0, 1, 0, '0);

        // R7 R4: pipelined write then read of the same word
        @(negedge clk_b);
        b_pipe = 1'b1;
        step_b(0, 1, 0, 22, 9'h1c3);
        expm[22] = 9'h1c3;
        step_b(0, 1, 1, 22, '0);
        chk("R7 pipe after write", b_rdata_oe, 0);
        step_b(1, 0, 1, 0, '0);
        chk("R4 write readback", b_rdata, expm[22]);

        finish_run();
    end
endmodule